// File: doc/BRIEF.md
# Index and Transfer Sequencer

This block is the part of a small interpreter CPU that handles the index register and the instructions that move bytes between the register file and memory. It owns the 16-bit index register and drives a single-port byte RAM. The RAM takes an address, write data and a write enable, and returns read data one cycle after the address. The block also connects to the register file through one combinational read port and one write port.

A host pulses `start` with an operation code and a register number `xSel`. The block then raises `busy` and works through the operation. This may be a single index update, a burst of three decimal digit writes, or a burst of register-to-memory or memory-to-register transfers covering registers 0 through `xSel`. It pulses `done` when the operation has finished. The decimal digits come from a repeated-subtraction datapath, so the block needs no divider.

Top module: `idx_xfer_engine`

## Requirements
- R1: Operation code 0 (index add) sets the index to index + V[x], with V[x] zero-extended and the sum wrapping modulo 2^16 (0x1200 + 0x34 = 0x1234, 0xFFFF + 0x02 = 0x0001).
- R2: Operation code 1 (glyph pointer) sets the index to V[x] * 5 (V[x] = 3 gives 15, V[x] = 0xFF gives 1275).
- R3: Operation code 2 (decimal split) writes the hundreds digit of V[x] to address I, the tens digit to I+1 and the ones digit to I+2, each as a byte value 0..9.
- R4: Operation code 3 (block store) writes V[0] through V[x] inclusive to addresses I through I+x. Addresses wrap modulo 2^16, and the byte at I+x+1 is left unchanged.
- R5: Operation code 4 (block load) fills V[0] through V[x] inclusive from addresses I through I+x and leaves the registers above x unchanged.
- R6: The decimal split, block store and block load operations leave the index register unchanged.
- R7: At most one memory access is made per cycle. The decimal split makes exactly 3 write cycles, the block store makes exactly x+1 write cycles and the block load makes none. Each loaded register receives the read data from the address issued in the previous cycle.
- R8: `busy` is high from the cycle after an accepted start until the operation completes. `done` is a single-cycle pulse that appears while `busy` is low.
- R9: A start strobe that arrives while `busy` is high is ignored and does not disturb the operation in progress.
- R10: Operation codes 5 to 7 do nothing: `done` pulses in the cycle after the strobe, `busy` stays low, and neither the index nor memory changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when the block is idle |
| opSel | input | 3 | Operation code (0 add, 1 glyph, 2 decimal split, 3 store, 4 load) |
| xSel | input | 4 | Register number x |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| indexOut | output | 16 | Current index register value |
| memAddr | output | 16 | RAM address |
| memWdata | output | 8 | RAM write data |
| memWe | output | 1 | RAM write enable |
| memRdata | input | 8 | RAM read data, one cycle after the address |
| regRdAddr | output | 4 | Register file read address |
| regRdData | input | 8 | Register file read data (combinational) |
| regWrEn | output | 1 | Register file write enable |
| regWrAddr | output | 4 | Register file write address |
| regWrData | output | 8 | Register file write data |

## Verification
The decimal split is exercised with the values 0, 9, 10, 99, 100, 128, 234 and 255. Together these hit both edges of each subtraction loop, so a wrong comparison threshold or an off-by-one iteration count shows up as a wrong digit. Block store is run with x = 0, with x = 2 and with a span that wraps past address 0xFFFF, which separates span-length errors from address-arithmetic errors. Block load is run with a partial span and with the full span of 16 registers, which shows whether the read latency is respected and whether the registers above x are left alone. The index add is tried both with and without carry-out wrap. A second start strobe is also issued in the middle of a long store.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  localparam int XFER_REG_IDX_W = 4;

  typedef enum logic [2:0] {
    OP_IDX_ADD = 3'd0,
    OP_GLYPH   = 3'd1,
    OP_DEC     = 3'd2,
    OP_STORE   = 3'd3,
    OP_LOAD    = 3'd4
  } xferOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                      idxAdd;
    logic                      idxGlyph;
    logic                      bcdLoad;
    logic                      bcdStepH;
    logic                      bcdStepT;
    logic                      wrBcd;
    logic [XFER_REG_IDX_W-1:0] offset;
  } xferStrobes_t;

endpackage

// File: rtl/xfer_dp.sv
module xfer_dp
  import xfer_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int GLYPH_BYTES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xferStrobes_t      stb,
  input  logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] idx,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              hundGe,
  output logic              tenGe
);

  localparam int DIGIT_W = 4;
  localparam logic [ADDR_W-1:0] GLYPH_STRIDE = ADDR_W'(GLYPH_BYTES);
  localparam logic [DATA_W-1:0] HUNDRED      = DATA_W'(100);
  localparam logic [DATA_W-1:0] TEN          = DATA_W'(10);

  logic [DATA_W-1:0]  work;
  logic [DIGIT_W-1:0] hund;
  logic [DIGIT_W-1:0] tens;
  logic [DIGIT_W-1:0] digit;

  assign hundGe = work >= HUNDRED;
  assign tenGe  = work >= TEN;

  // index register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (stb.idxAdd) begin
      idx <= idx + ADDR_W'(regRdData);
    end else if (stb.idxGlyph) begin
      idx <= ADDR_W'(regRdData) * GLYPH_STRIDE;
    end
  end

  // repeated-subtraction decimal split
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work <= '0;
      hund <= '0;
      tens <= '0;
    end else if (stb.bcdLoad) begin
      work <= regRdData;
      hund <= '0;
      tens <= '0;
    end else if (stb.bcdStepH) begin
      work <= work - HUNDRED;
      hund <= hund + 1'b1;
    end else if (stb.bcdStepT) begin
      work <= work - TEN;
      tens <= tens + 1'b1;
    end
  end

  always_comb begin
    case (stb.offset)
      XFER_REG_IDX_W'(0): digit = hund;
      XFER_REG_IDX_W'(1): digit = tens;
      default:            digit = work[DIGIT_W-1:0];
    endcase
  end

  assign memAddr  = idx + ADDR_W'(stb.offset);
  assign memWdata = stb.wrBcd ? DATA_W'(digit) : regRdData;

  // R3: every digit written is a decimal digit
  a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrBcd |-> (hund <= DIGIT_W'(2) && tens < DIGIT_W'(10) && work < TEN));

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [2:0]                opSel,
  input  logic [XFER_REG_IDX_W-1:0] xSel,
  input  logic                      hundGe,
  input  logic                      tenGe,
  output xferStrobes_t              stb,
  output logic                      busy,
  output logic                      done,
  output logic                      memWe,
  output logic                      regWrEn,
  output logic [XFER_REG_IDX_W-1:0] regWrAddr,
  output logic [XFER_REG_IDX_W-1:0] regRdAddr
);

  typedef enum logic [3:0] {
    S_IDLE, S_SINGLE, S_DEC_FETCH, S_DEC_H, S_DEC_T, S_DEC_WR,
    S_STORE, S_LD_RD, S_LD_WR
  } state_e;

  localparam logic [XFER_REG_IDX_W-1:0] LAST_DIGIT = XFER_REG_IDX_W'(2);

  state_e                    state;
  logic                      glyphQ;
  logic [XFER_REG_IDX_W-1:0] xQ;
  logic [XFER_REG_IDX_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      glyphQ <= 1'b0;
      xQ     <= '0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          xQ     <= xSel;
          cnt    <= '0;
          glyphQ <= (opSel == OP_GLYPH);
          case (opSel)
            OP_IDX_ADD, OP_GLYPH: state <= S_SINGLE;
            OP_DEC:               state <= S_DEC_FETCH;
            OP_STORE:             state <= S_STORE;
            OP_LOAD:              state <= S_LD_RD;
            default:              done  <= 1'b1;
          endcase
        end
        S_SINGLE: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        S_DEC_FETCH: state <= S_DEC_H;
        S_DEC_H:     if (!hundGe) state <= S_DEC_T;
        S_DEC_T:     if (!tenGe) state <= S_DEC_WR;
        S_DEC_WR: begin
          if (cnt == LAST_DIGIT) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STORE: begin
          if (cnt == xQ) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LD_RD: state <= S_LD_WR;
        S_LD_WR: begin
          if (cnt == xQ) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            cnt   <= cnt + 1'b1;
            state <= S_LD_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb        = '0;
    stb.offset = cnt;
    memWe      = 1'b0;
    regWrEn    = 1'b0;
    case (state)
      S_SINGLE: begin
        stb.idxAdd   = !glyphQ;
        stb.idxGlyph = glyphQ;
      end
      S_DEC_FETCH: stb.bcdLoad  = 1'b1;
      S_DEC_H:     stb.bcdStepH = hundGe;
      S_DEC_T:     stb.bcdStepT = tenGe;
      S_DEC_WR: begin
        stb.wrBcd = 1'b1;
        memWe     = 1'b1;
      end
      S_STORE: memWe   = 1'b1;
      S_LD_WR: regWrEn = 1'b1;
      default: ;
    endcase
  end

  assign busy      = (state != S_IDLE);
  assign regWrAddr = cnt;
  assign regRdAddr = (state == S_STORE) ? cnt : xQ;

  // R8: completion pulse lasts one cycle and comes with busy low
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7: a register load uses data addressed in the previous cycle
  a_r7_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |-> $past(state == S_LD_RD));
  // R7: never a write and a read issue together
  a_r7_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({memWe, state == S_LD_RD}));
  // R9: captured operand untouched by a strobe during busy
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(xQ));

endmodule

// File: rtl/idx_xfer_engine.sv
module idx_xfer_engine
  import xfer_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int GLYPH_BYTES = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [2:0]                opSel,
  input  logic [XFER_REG_IDX_W-1:0] xSel,
  output logic                      busy,
  output logic                      done,
  output logic [ADDR_W-1:0]         indexOut,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [DATA_W-1:0]         memWdata,
  output logic                      memWe,
  input  logic [DATA_W-1:0]         memRdata,
  output logic [XFER_REG_IDX_W-1:0] regRdAddr,
  input  logic [DATA_W-1:0]         regRdData,
  output logic                      regWrEn,
  output logic [XFER_REG_IDX_W-1:0] regWrAddr,
  output logic [DATA_W-1:0]         regWrData
);

  xferStrobes_t stb;
  logic         hundGe;
  logic         tenGe;

  xfer_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .opSel     (opSel),
    .xSel      (xSel),
    .hundGe    (hundGe),
    .tenGe     (tenGe),
    .stb       (stb),
    .busy      (busy),
    .done      (done),
    .memWe     (memWe),
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .regRdAddr (regRdAddr)
  );

  xfer_dp #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .GLYPH_BYTES (GLYPH_BYTES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .regRdData (regRdData),
    .idx       (indexOut),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .hundGe    (hundGe),
    .tenGe     (tenGe)
  );

  assign regWrData = memRdata;

  // R6: transfers never move the index
  a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (memWe || regWrEn) |=> $stable(indexOut));

endmodule

// File: tb/idx_xfer_engine_bench.sv
module idx_xfer_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] OP_ADD = 3'd0, OP_GLY = 3'd1, OP_DEC = 3'd2,
                         OP_ST = 3'd3, OP_LD = 3'd4;
  localparam int NVEC = 8;
  // {index[15:0], value[7:0]}
  localparam logic [23:0] DEC_VEC [NVEC] = '{
    {16'h0030, 8'd234}, {16'h0040, 8'd0},   {16'h0050, 8'd9},
    {16'h0060, 8'd10},  {16'h0070, 8'd99},  {16'h0080, 8'd100},
    {16'h0090, 8'd255}, {16'h00A0, 8'd128}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  opSel;
  logic [3:0]  xSel;
  logic        busy, done, memWe, regWrEn;
  logic [15:0] indexOut, memAddr;
  logic [7:0]  memWdata, memRdata, regRdData, regWrData;
  logic [3:0]  regRdAddr, regWrAddr;

  logic [7:0] mem [256];
  logic [7:0] regs [16];
  int weCount = 0;
  int checks = 0;
  int fails = 0;
  logic busySeen;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_xfer_engine u_idx_xfer_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .opSel(opSel), .xSel(xSel),
    .busy(busy), .done(done), .indexOut(indexOut), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata),
    .regRdAddr(regRdAddr), .regRdData(regRdData), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData)
  );

  assign regRdData = regs[regRdAddr];

  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr[7:0]] <= memWdata;
      weCount = weCount + 1;
    end
    memRdata <= mem[memAddr[7:0]];
    if (regWrEn) regs[regWrAddr] <= regWrData;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] o, input logic [3:0] x);
    int wd;
    @(negedge clk);
    start = 1'b1; opSel = o; xSel = x;
    @(negedge clk);
    start = 1'b0;
    busySeen = busy;
    wd = 0;
    while (!done && wd < 400) begin
      @(negedge clk);
      wd++;
    end
    if (wd >= 400) chk("R8 watchdog on done", 0, 1);
  endtask

  task automatic setIndex(input int val);
    int rem;
    regs[14] = 8'd0;
    runOp(OP_GLY, 4'd14);
    rem = val;
    while (rem > 255) begin
      regs[14] = 8'd255;
      runOp(OP_ADD, 4'd14);
      rem -= 255;
    end
    regs[14] = 8'(rem);
    runOp(OP_ADD, 4'd14);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    for (int i = 0; i < 16; i++) regs[i] = 8'h00;
    rst_n = 1'b0; start = 1'b0; opSel = '0; xSel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset busy", busy, 0);
    chk("R8 reset done", done, 0);
    chk("R1 reset index", indexOut, 0);
    chk("R7 reset memWe", memWe, 0);
    chk("R5 reset regWrEn", regWrEn, 0);

    // R3 table walk: decimal split
    for (int v = 0; v < NVEC; v++) begin
      int base, val;
      base = int'(DEC_VEC[v][23:8]);
      val  = int'(DEC_VEC[v][7:0]);
      setIndex(base);
      regs[2] = 8'(val);
      weCount = 0;
      runOp(OP_DEC, 4'd2);
      chk("R8 busy during split", busySeen, 1);
      chk("R8 done with busy low", busy, 0);
      chk("R3 hundreds", mem[base], val / 100);
      chk("R3 tens", mem[base+1], (val / 10) % 10);
      chk("R3 ones", mem[base+2], val % 10);
      chk("R3 neighbour", mem[base+3], 8'hEE);
      chk("R7 split writes", weCount, 3);
      chk("R6 index after split", indexOut, base);
    end

    // R1 index add
    setIndex(16'h1200);
    regs[3] = 8'h34;
    runOp(OP_ADD, 4'd3);
    chk("R1 add", indexOut, 16'h1234);
    setIndex(16'hFFFF);
    regs[5] = 8'h02;
    runOp(OP_ADD, 4'd5);
    chk("R1 wrap", indexOut, 16'h0001);

    // R2 glyph pointer
    regs[5] = 8'h03;
    runOp(OP_GLY, 4'd5);
    chk("R2 glyph 3", indexOut, 15);
    regs[7] = 8'hFF;
    runOp(OP_GLY, 4'd7);
    chk("R2 glyph ff", indexOut, 1275);
    regs[0] = 8'h00;
    runOp(OP_GLY, 4'd0);
    chk("R2 glyph 0", indexOut, 0);

    // R4 block store
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    setIndex(16'h0030);
    regs[0] = 8'd5; regs[1] = 8'd4; regs[2] = 8'd3;
    weCount = 0;
    runOp(OP_ST, 4'd2);
    chk("R4 store b0", mem[8'h30], 5);
    chk("R4 store b1", mem[8'h31], 4);
    chk("R4 store b2", mem[8'h32], 3);
    chk("R4 store beyond", mem[8'h33], 8'hEE);
    chk("R7 store writes", weCount, 3);
    chk("R6 index after store", indexOut, 16'h0030);
    setIndex(16'h0040);
    regs[0] = 8'h77;
    weCount = 0;
    runOp(OP_ST, 4'd0);
    chk("R4 store x0", mem[8'h40], 8'h77);
    chk("R4 store x0 beyond", mem[8'h41], 8'hEE);
    chk("R7 store x0 writes", weCount, 1);
    setIndex(16'hFFFF);
    regs[0] = 8'hA1; regs[1] = 8'hA2;
    runOp(OP_ST, 4'd1);
    chk("R4 store wrap top", mem[8'hFF], 8'hA1);
    chk("R4 store wrap zero", mem[8'h00], 8'hA2);
    chk("R4 store wrap beyond", mem[8'h01], 8'hEE);

    // R5 block load
    for (int i = 0; i < 16; i++) mem[8'h80 + i] = 8'(i * 3 + 1);
    setIndex(16'h0080);
    for (int i = 0; i < 16; i++) regs[i] = 8'h55;
    weCount = 0;
    runOp(OP_LD, 4'd3);
    for (int i = 0; i < 4; i++) chk("R5 load partial", regs[i], i * 3 + 1);
    chk("R5 load above x", regs[4], 8'h55);
    chk("R7 load no writes", weCount, 0);
    chk("R6 index after load", indexOut, 16'h0080);
    runOp(OP_LD, 4'd15);
    for (int i = 0; i < 16; i++) chk("R5 load full", regs[i], i * 3 + 1);

    // R9 start while busy
    setIndex(16'h0020);
    for (int i = 0; i < 16; i++) regs[i] = 8'(8'h60 + i);
    @(negedge clk);
    start = 1'b1; opSel = OP_ST; xSel = 4'd15;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    start = 1'b1; opSel = OP_ADD; xSel = 4'd1;
    @(negedge clk);
    start = 1'b0;
    begin
      int wd;
      wd = 0;
      while (!done && wd < 100) begin
        @(negedge clk);
        wd++;
      end
    end
    chk("R9 index kept", indexOut, 16'h0020);
    chk("R9 store last byte", mem[8'h2F], 8'h6F);
    repeat (2) @(negedge clk);
    chk("R9 no extra busy", busy, 0);
    chk("R9 no extra done", done, 0);

    // R10 unused operation code
    weCount = 0;
    mem[8'h20] = 8'hC3;
    runOp(3'd6, 4'd1);
    chk("R10 busy stays low", busySeen, 0);
    chk("R10 done pulse", done, 1);
    chk("R10 index kept", indexOut, 16'h0020);
    chk("R10 no writes", weCount, 0);
    chk("R10 memory kept", mem[8'h20], 8'hC3);
    @(negedge clk);
    chk("R8 done one cycle", done, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule